// File: doc/BRIEF.md
# Fluorescent Display Scan Sequencer

This block drives a multiplexed vacuum fluorescent display from a display RAM that sits outside it. Software programs a start address, a scan length and a dimmer duty through a small register write port. Display runs only while both the auto-display enable and the display-start bit are set. While it runs, the block divides time into display slots of `SLOT_CYC` clocks. A down-counting pointer chooses one RAM entry per slot, and that entry's segment data is driven onto the segment bus for the whole slot.

With gradation mode on, the block makes a second read for each slot, at the display address minus `GRAD_OFF` (modulo 256). That word carries one brightness bit per segment pin. A pin whose bit is 0 is driven for the full slot. A pin whose bit is 1 is driven only for the first `duty` clocks of the slot. A blanking interrupt pulses once every 1, 2 or 3 slots, and each pulse also sets a sticky flag that software clears.

Register map, written through `wr_en`/`wr_addr`/`wr_data`:

| Address | Field |
|---|---|
| 0 | control: bit0 auto-display enable, bit1 display start, bit2 gradation mode, bits[4:3] interrupt period in slots (0 or 1 gives 1), bit5 write 1 to clear the sticky flag |
| 1 | first (highest) display address |
| 2 | pointer reload count N (a scan covers N+1 slots) |
| 3 | dimmer duty, in clocks per slot |

Top module: `vfd_scan_seq`

## Requirements
- R1: While control bit0 or bit1 is 0, `ram_rd_en` stays low and `seg_out` stays 0.
- R2: After start, displayed slot k (k = 1, 2, ...) shows RAM[(first - ((k-1) mod (N+1))) mod 256]. The pointer counts down and reloads when it would pass 0 to 0xFF.
- R3: The first `SLOT_CYC` clocks after start are a blank lead-in. After that, the committed data changes only on slot boundaries, every `SLOT_CYC` clocks.
- R4: In gradation mode, the brightness word for a slot is read from (slot address - `GRAD_OFF`) mod 256.
- R5: In gradation mode, a pin with brightness bit 1 is driven only while the in-slot clock count is below the duty value. A pin with brightness bit 0 is driven for the whole slot.
- R6: Writing 0 to control bit1 forces `seg_out` and `dim_out` to 0 from the very next cycle.
- R7: After a stop, the next start begins again at the first address.
- R8: `blank_irq` is a one-cycle pulse in the first cycle of every P-th displayed slot, where P is taken from control bits[4:3] (0 is treated as 1).
- R9: `blank_flag` goes to 1 with each interrupt pulse and holds until a control write with bit5 set.
- R10: With gradation mode off, every pin is driven for the whole slot, whatever the duty value.
- R11: While running, `dim_out` is 1 exactly while the in-slot clock count is below the duty value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| ram_rd_en | output | 1 | Display RAM read strobe |
| ram_addr | output | 8 | Display RAM read address |
| ram_rdata | input | SEG_W | Display RAM read data, valid one cycle after the strobe |
| seg_out | output | SEG_W | Segment drive bus |
| dim_out | output | 1 | Dimmer/blanking output |
| blank_irq | output | 1 | Blanking interrupt pulse |
| blank_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with `SLOT_CYC` = 8 and the default 0x70 gradation offset and 8-bit segment bus. Short slots keep scans of up to 20 slots cheap, so pointer wrap, reload on restart and every interrupt period all fit in one run. A 16-slot gradation scan checks both phases of a slot (inside and past the duty window). A start address just above zero makes both the display address and the gradation address wrap through 0xFF.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  localparam int ADDR_W = 8;

  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_FIRST  = 2'd1;
  localparam logic [1:0] REG_RELOAD = 2'd2;
  localparam logic [1:0] REG_DUTY   = 2'd3;

  typedef struct packed {
    logic [1:0] spare;
    logic       clr;
    logic [1:0] period;
    logic       grad;
    logic       start;
    logic       auto_en;
  } ctrl_t;
endpackage

// File: rtl/vfd_regs.sv
module vfd_regs
  import vfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output ctrl_t             ctrl,
  output logic [ADDR_W-1:0] first,
  output logic [ADDR_W-1:0] reload,
  output logic [7:0]        duty,
  output logic              flag_clr
);
  ctrl_t             ctrl_d;
  logic [ADDR_W-1:0] first_d, reload_d;
  logic [7:0]        duty_d;
  logic              ctrl_we, first_we, reload_we, duty_we;

  always_comb begin
    ctrl_we   = wr_en && (wr_addr == REG_CTRL);
    first_we  = wr_en && (wr_addr == REG_FIRST);
    reload_we = wr_en && (wr_addr == REG_RELOAD);
    duty_we   = wr_en && (wr_addr == REG_DUTY);
    ctrl_d    = ctrl_t'(wr_data);
    ctrl_d.clr = 1'b0;
    first_d   = wr_data[ADDR_W-1:0];
    reload_d  = wr_data[ADDR_W-1:0];
    duty_d    = wr_data;
    flag_clr  = ctrl_we && wr_data[5];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      first  <= '0;
      reload <= '0;
      duty   <= '0;
    end else begin
      if (ctrl_we)   ctrl   <= ctrl_d;
      if (first_we)  first  <= first_d;
      if (reload_we) reload <= reload_d;
      if (duty_we)   duty   <= duty_d;
    end
  end
endmodule

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer #(
  parameter int SLOT_CYC = 16,
  localparam int CYC_W = $clog2(SLOT_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       period,
  input  logic [7:0]       duty,
  input  logic             flag_clr,
  output logic [CYC_W-1:0] cyc,
  output logic             bnd,
  output logic             duty_on,
  output logic             irq,
  output logic             flag
);
  localparam logic [CYC_W-1:0] LAST = CYC_W'(SLOT_CYC - 1);

  logic [CYC_W-1:0] cyc_d;
  logic [1:0]       scnt, scnt_d, per_n;
  logic             irq_d, flag_d, hit;

  always_comb begin
    bnd     = run && (cyc == LAST);
    duty_on = run && ({{(8-CYC_W){1'b0}}, cyc} < duty);
    per_n   = (period == 2'd0) ? 2'd1 : period;
    hit     = bnd && (scnt == per_n - 2'd1);
    cyc_d   = cyc;
    scnt_d  = scnt;
    if (!run) begin
      cyc_d  = '0;
      scnt_d = '0;
    end else begin
      cyc_d = bnd ? '0 : cyc + 1'b1;
      if (bnd) scnt_d = hit ? 2'd0 : scnt + 2'd1;
    end
    irq_d  = hit;
    flag_d = hit ? 1'b1 : (flag_clr ? 1'b0 : flag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc  <= '0;
      scnt <= '0;
      irq  <= 1'b0;
      flag <= 1'b0;
    end else begin
      cyc  <= cyc_d;
      scnt <= scnt_d;
      irq  <= irq_d;
      flag <= flag_d;
    end
  end
endmodule

// File: rtl/vfd_fetch.sv
module vfd_fetch
  import vfd_pkg::*;
#(
  parameter int SEG_W    = 8,
  parameter int SLOT_CYC = 16,
  parameter logic [ADDR_W-1:0] GRAD_OFF = 8'h70,
  localparam int CYC_W = $clog2(SLOT_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              grad_en,
  input  logic [ADDR_W-1:0] first,
  input  logic [ADDR_W-1:0] reload,
  input  logic [CYC_W-1:0]  cyc,
  input  logic              bnd,
  input  logic [SEG_W-1:0]  ram_rdata,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [SEG_W-1:0]  seg_q,
  output logic [SEG_W-1:0]  grad_q,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [CYC_W-1:0] RD_SEG  = CYC_W'(SLOT_CYC - 3);
  localparam logic [CYC_W-1:0] RD_GRAD = CYC_W'(SLOT_CYC - 2);

  logic [ADDR_W-1:0] slot_addr, ptr_d, ptr_dec;
  logic [SEG_W-1:0]  stage, stage_d, seg_d, grad_d;
  logic              rd_seg, rd_grad;

  always_comb begin
    slot_addr = first - (reload - ptr);
    rd_seg    = run && (cyc == RD_SEG);
    rd_grad   = run && grad_en && (cyc == RD_GRAD);
    ram_rd_en = rd_seg || rd_grad;
    ram_addr  = rd_grad ? (slot_addr - GRAD_OFF) : slot_addr;
    ptr_dec   = ptr - 1'b1;
    ptr_d     = ptr;
    stage_d   = stage;
    seg_d     = seg_q;
    grad_d    = grad_q;
    if (!run) begin
      ptr_d   = reload;
      stage_d = '0;
      seg_d   = '0;
      grad_d  = '0;
    end else begin
      if (cyc == RD_GRAD) stage_d = ram_rdata;
      if (bnd) begin
        seg_d  = stage;
        grad_d = grad_en ? ram_rdata : '0;
        ptr_d  = (ptr_dec == '1) ? reload : ptr_dec;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      stage  <= '0;
      seg_q  <= '0;
      grad_q <= '0;
    end else begin
      ptr    <= ptr_d;
      stage  <= stage_d;
      seg_q  <= seg_d;
      grad_q <= grad_d;
    end
  end
endmodule

// File: rtl/vfd_scan_seq.sv
module vfd_scan_seq
  import vfd_pkg::*;
#(
  parameter int SEG_W    = 8,
  parameter int SLOT_CYC = 16,
  parameter logic [7:0] GRAD_OFF = 8'h70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic [SEG_W-1:0]  ram_rdata,
  output logic [SEG_W-1:0]  seg_out,
  output logic              dim_out,
  output logic              blank_irq,
  output logic              blank_flag
);
  localparam int CYC_W = $clog2(SLOT_CYC);

  logic              rs_meta, rst_sync_n;
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] first, reload, ptr;
  logic [7:0]        duty;
  logic              flag_clr, run, bnd, duty_on;
  logic [CYC_W-1:0]  cyc;
  logic [SEG_W-1:0]  seg_q, grad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_meta    <= 1'b1;
      rst_sync_n <= rs_meta;
    end
  end

  vfd_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .first(first), .reload(reload),
    .duty(duty), .flag_clr(flag_clr)
  );

  assign run = ctrl.auto_en && ctrl.start;

  vfd_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .period(ctrl.period),
    .duty(duty), .flag_clr(flag_clr), .cyc(cyc), .bnd(bnd),
    .duty_on(duty_on), .irq(blank_irq), .flag(blank_flag)
  );

  vfd_fetch #(.SEG_W(SEG_W), .SLOT_CYC(SLOT_CYC), .GRAD_OFF(GRAD_OFF)) u_fetch (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .grad_en(ctrl.grad),
    .first(first), .reload(reload), .cyc(cyc), .bnd(bnd),
    .ram_rdata(ram_rdata), .ram_rd_en(ram_rd_en), .ram_addr(ram_addr),
    .seg_q(seg_q), .grad_q(grad_q), .ptr(ptr)
  );

  always_comb begin
    seg_out = run ? (seg_q & ~(grad_q & {SEG_W{~duty_on}})) : '0;
    dim_out = duty_on;
  end
endmodule

// File: rtl/vfd_scan_seq_chk.sv
module vfd_scan_seq_chk #(
  parameter int SEG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             bnd,
  input logic [SEG_W-1:0] seg_q,
  input logic [7:0]       ptr,
  input logic [7:0]       reload,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             ram_rd_en,
  input logic             blank_irq,
  input logic             blank_flag
);
  // R1: no RAM traffic unless both enables are set
  p_no_read_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !ram_rd_en);

  // R3: committed data only moves on a slot boundary (or a stop)
  p_hold_in_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bnd) |=> (!run || $stable(seg_q)));

  // R2: pointer reloads instead of passing below zero
  p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && ptr == 8'd0 && !(wr_en && wr_addr == 2'd2)) |=> (ptr == $past(reload)));

  // R8: interrupt is a single-cycle pulse
  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blank_irq |=> !blank_irq);

  // R9: every pulse leaves the sticky flag set
  p_irq_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blank_irq |-> blank_flag);
endmodule

bind vfd_scan_seq vfd_scan_seq_chk #(.SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .run(run), .bnd(bnd), .seg_q(seg_q),
  .ptr(ptr), .reload(reload), .wr_en(wr_en), .wr_addr(wr_addr),
  .ram_rd_en(ram_rd_en), .blank_irq(blank_irq), .blank_flag(blank_flag)
);

// File: tb/vfd_scan_seq_bench.sv
module vfd_scan_seq_bench;
  localparam int S = 8;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [1:0]   wr_addr;
  logic [7:0]   wr_data;
  logic         ram_rd_en;
  logic [7:0]   ram_addr;
  logic [W-1:0] ram_rdata;
  logic [W-1:0] seg_out;
  logic         dim_out, blank_irq, blank_flag;

  always #5 clk = ~clk;

  vfd_scan_seq #(.SEG_W(W), .SLOT_CYC(S), .GRAD_OFF(8'h70)) u_vfd_scan_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ram_rd_en(ram_rd_en), .ram_addr(ram_addr),
    .ram_rdata(ram_rdata), .seg_out(seg_out), .dim_out(dim_out),
    .blank_irq(blank_irq), .blank_flag(blank_flag)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  logic [7:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = pat(i);
  always @(posedge clk) if (ram_rd_en) ram_rdata <= mem[ram_addr];

  int errors = 0;
  int checks = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct { logic [7:0] seg; logic [7:0] grad; } item_t;
  item_t q[$];
  item_t cur;

  int  mon_edges = 0;
  bit  mon_on = 0;
  int  mon_lim = 0;
  int  mon_duty = 0;
  int  mon_per = 1;
  bit  rd_seen = 0;

  always @(posedge clk) begin
    if (mon_on) mon_edges <= mon_edges + 1;
    if (ram_rd_en) rd_seen <= 1'b1;
  end

  function automatic logic [7:0] expo(input item_t it, input int j);
    return it.seg & ~(it.grad & ((j < mon_duty) ? 8'h00 : 8'hFF));
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      int n, j;
      n = mon_edges / S;
      j = mon_edges % S;
      if (n == 0) begin
        if (j == 2) check("R3 lead-in blank", int'(seg_out), 0);
      end else if (n <= mon_lim) begin
        if (j == 0) begin
          if (q.size() == 0) check("R2 queue underflow", 1, 0);
          else cur = q.pop_front();
          check("R8 irq at slot start", int'(blank_irq), int'((n % mon_per) == 0));
        end
        if (j == 0 || j == S - 1) begin
          check("R2/R5/R10 segment drive", int'(seg_out), int'(expo(cur, j)));
          check("R11 dimmer output", int'(dim_out), int'(j < mon_duty));
        end
        if (j == 3) check("R8 irq low mid-slot", int'(blank_irq), 0);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic run_scan(input logic [7:0] first, input logic [7:0] cnt,
                          input bit grad, input logic [7:0] duty,
                          input logic [1:0] per, input int nslots);
    wr(2'd1, first);
    wr(2'd2, cnt);
    wr(2'd3, duty);
    for (int k = 1; k <= nslots; k++) begin
      item_t it;
      int idx, a;
      idx = (k - 1) % (int'(cnt) + 1);
      a = (int'(first) - idx) & 255;
      it.seg  = mem[a];
      it.grad = grad ? mem[(a - 'h70) & 255] : 8'h00;
      q.push_back(it);
    end
    mon_lim  = nslots;
    mon_duty = duty;
    mon_per  = (per == 0) ? 1 : per;
    wr(2'd0, {3'b000, per, grad, 2'b11});
    mon_edges = 0;
    mon_on = 1;
    repeat (nslots * S + S) @(posedge clk);
    #1 mon_on = 0;
    wr(2'd0, 8'h00);
    check("R2 all slots seen", q.size(), 0);
    q.delete();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wr_en = 0; wr_addr = 0; wr_data = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("reset seg_out", int'(seg_out), 0);
    check("reset irq", int'(blank_irq), 0);
    check("reset flag", int'(blank_flag), 0);
    check("reset rd_en", int'(ram_rd_en), 0);

    // R1: start bit alone does nothing
    wr(2'd1, 8'h40);
    rd_seen = 0;
    wr(2'd0, 8'h02);
    repeat (3 * S) @(posedge clk);
    @(negedge clk);
    check("R1 start-only seg_out", int'(seg_out), 0);
    check("R1 start-only no read", int'(rd_seen), 0);
    wr(2'd0, 8'h01);
    repeat (3 * S) @(posedge clk);
    @(negedge clk);
    check("R1 auto-only no read", int'(rd_seen), 0);
    wr(2'd0, 8'h00);

    // R2 R10 R8 R11: plain scan with wrap, duty 5 ignored by segments
    run_scan(8'h90, 8'd3, 1'b0, 8'd5, 2'd0, 10);

    // R4 R5 R8: gradation, 16 slots, period 3
    run_scan(8'h85, 8'd15, 1'b1, 8'd3, 2'd3, 20);

    // R9: flag sticky after stop, cleared by bit5
    @(negedge clk);
    check("R9 flag sticky", int'(blank_flag), 1);
    wr(2'd0, 8'h20);
    @(negedge clk);
    check("R9 flag cleared", int'(blank_flag), 0);

    // R6: stop takes effect next cycle
    wr(2'd1, 8'h30);
    wr(2'd2, 8'd7);
    wr(2'd3, 8'd6);
    wr(2'd0, 8'h03);
    repeat (2 * S + 3) @(posedge clk);
    @(negedge clk);
    check("R6 running before stop", int'(seg_out), int'(mem[8'h2F]));
    wr(2'd0, 8'h01);
    @(negedge clk);
    check("R6 seg_out off after stop", int'(seg_out), 0);
    check("R6 dim_out off after stop", int'(dim_out), 0);
    wr(2'd0, 8'h00);

    // R7: restart begins at first address again
    run_scan(8'h30, 8'd7, 1'b0, 8'd0, 2'd1, 3);

    // R2 R4: addresses wrap through 0xFF
    run_scan(8'h02, 8'd5, 1'b1, 8'd2, 2'd2, 8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule